// File: doc/BRIEF.md
# CAN power-save mode controller

This block holds the power state of a CAN controller and decides which host requests may act on it. Software writes a two-bit mode code. From these codes the block moves between an operating state, a sleep state and a stop state. Stop is a deeper level that can be reached only through sleep. The block drives the clock enable of the controller core. It grants or refuses host access to the message buffers and to module registers. It also gates transmit and initialization requests.

While the controller sleeps, the block samples the CAN receive pin through a synchronizer. Any level change on that pin returns the controller to operating by hardware. The stored mode code stays at the sleep value until software writes the operating code itself. While the stored code is stale, a stop request finds the controller out of sleep and is refused. This holds even when the request arrives in the same cycle as the wake. Each refused request leaves the state and the stored code unchanged and produces a one-cycle pulse on `req_ign`.

Top module: `canpwr_ctrl`

## Requirements
- R1: After reset, `pstate` is 00, `mode_field` is 00, `clk_en` is 1, and both `req_ign` and `bufon` are 0.
- R2: In operating state (00), writing code 01 moves to sleep and `mode_field` becomes 01. In sleep, writing code 00 returns to operating and `mode_field` becomes 00. Each change shows after the clock edge that takes the write.
- R3: Code 11 moves the state to stop (`pstate` 11, `mode_field` 11) only when the state is sleep. In every other state the write is refused: `req_ign` pulses for one cycle, and state and stored code stay as they were.
- R4: In stop, the only accepted write is code 01, which moves to sleep. Codes 00, 10 and 11 are refused with a `req_ign` pulse. A level change on `rxd` during stop does not change the state.
- R5: In stop, `clk_en`, `tx_go`, `buf_grant` and `reg_wr_grant` are 0 whatever the requests.
- R6: In stop, `rd_grant` is 0 for the four pointer addresses 0x24, 0x26, 0x28 and 0x2A and equals `rd_en` for every other address. In the other states `rd_grant` equals `rd_en`.
- R7: `bufon` is set by `bufon_set` outside stop. It is 0 from the edge that enters stop, and `bufon_set` has no effect during stop.
- R8: `init_go` follows `init_req` only in operating state. In sleep or stop, an `init_req` gives `init_go` 0 and a `req_ign` pulse.
- R9: In sleep, a level change on `rxd` returns `pstate` to 00 while `mode_field` stays 01 until code 00 is written. A code 11 write in that period, including one in the very cycle of the wake, is refused.
- R10: Code 10 is never accepted. It gives a `req_ign` pulse and no state change.
- R11: `tx_go` follows `tx_req` only in operating state. It is 0 in sleep and in stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | CAN receive pin, asynchronous, idle high |
| mode_wr | input | 1 | Write strobe for the mode code |
| mode_wdata | input | 2 | Mode code written |
| reg_wr | input | 1 | Host write to any other module register |
| rd_en | input | 1 | Host register read request |
| rd_addr | input | AW (8) | Register read address |
| buf_req | input | 1 | Host message-buffer access request |
| tx_req | input | 1 | Transmit request from the protocol side |
| init_req | input | 1 | Request to enter initialization |
| bufon_set | input | 1 | Protocol engine reports buffers accessible |
| clk_en | output | 1 | Core clock enable |
| pstate | output | 2 | Power state: 00 operating, 01 sleep, 11 stop |
| mode_field | output | 2 | Stored mode code as read back |
| req_ign | output | 1 | One-cycle pulse for a refused request |
| reg_wr_grant | output | 1 | Register write allowed |
| rd_grant | output | 1 | Register read allowed |
| buf_grant | output | 1 | Message-buffer access allowed |
| tx_go | output | 1 | Transmission allowed |
| init_go | output | 1 | Initialization request accepted |
| bufon | output | 1 | Message-buffer-access status flag |

## Verification
The hardest case to reach is a stop request that lands in the same cycle that the synchronized receive-pin change cancels sleep. With the two-stage synchronizer, the wake is seen during the second cycle after `rxd` changes. The stimulus therefore flips `rxd` at a falling edge, lets two rising edges pass, and then presents the 11 write. The checks expect operating state, a stale 01 code and a refusal pulse. A second hard case is a pin change during stop. The bench waits long enough for the synchronizer to consume that change, then leaves stop and confirms that sleep is held and is not cut short.

// File: rtl/canpwr_pkg.sv
package canpwr_pkg;

   typedef enum logic [1:0] {
      PS_RUN   = 2'b00,
      PS_SLEEP = 2'b01,
      PS_STOP  = 2'b11
   } pstate_e;

   localparam logic [1:0] MC_RUN   = 2'b00;
   localparam logic [1:0] MC_SLEEP = 2'b01;
   localparam logic [1:0] MC_BAD   = 2'b10;
   localparam logic [1:0] MC_STOP  = 2'b11;

endpackage

// File: rtl/canpwr_rx_wake.sv
module canpwr_rx_wake #(
   parameter int   SYNC_STAGES   = 2,
   parameter bit   WAKE_ANY_EDGE = 1'b1,
   parameter logic IDLE_LEVEL    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rxd,
   output logic edge_o
);

   localparam int LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("canpwr_rx_wake: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] sync_q;
   logic          prev_q;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= IDLE_LEVEL;
               else        sync_q[0] <= rxd;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= IDLE_LEVEL;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LEVEL;
      else        prev_q <= sync_q[LAST];
   end

   generate
      if (WAKE_ANY_EDGE) begin : g_any
         assign edge_o = sync_q[LAST] ^ prev_q;
      end else begin : g_fall
         assign edge_o = prev_q & ~sync_q[LAST];
      end
   endgenerate

endmodule

// File: rtl/canpwr_fsm.sv
module canpwr_fsm
   import canpwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wake_i,
   input  logic       mode_wr,
   input  logic [1:0] mode_wdata,
   input  logic       init_req,
   output pstate_e    state_o,
   output logic [1:0] field_o,
   output logic       ign_o,
   output logic       stop_entry_o
);

   pstate_e    state_q, state_d;
   logic [1:0] field_q, field_d;
   logic       ign_q, ign_d;

   always_comb begin
      state_d = state_q;
      field_d = field_q;
      ign_d   = 1'b0;
      unique case (state_q)
         PS_RUN: begin
            if (mode_wr) begin
               if (mode_wdata == MC_RUN) begin
                  field_d = MC_RUN;
               end else if (mode_wdata == MC_SLEEP) begin
                  state_d = PS_SLEEP;
                  field_d = MC_SLEEP;
               end else begin
                  ign_d = 1'b1;
               end
            end
         end
         PS_SLEEP: begin
            if (wake_i) begin
               state_d = PS_RUN;
               if (mode_wr) begin
                  if (mode_wdata == MC_RUN) field_d = MC_RUN;
                  else                      ign_d   = 1'b1;
               end
            end else if (mode_wr) begin
               if (mode_wdata == MC_RUN) begin
                  state_d = PS_RUN;
                  field_d = MC_RUN;
               end else if (mode_wdata == MC_STOP) begin
                  state_d = PS_STOP;
                  field_d = MC_STOP;
               end else if (mode_wdata == MC_BAD) begin
                  ign_d = 1'b1;
               end
            end
         end
         PS_STOP: begin
            if (mode_wr) begin
               if (mode_wdata == MC_SLEEP) begin
                  state_d = PS_SLEEP;
                  field_d = MC_SLEEP;
               end else begin
                  ign_d = 1'b1;
               end
            end
         end
         default: begin
            state_d = PS_RUN;
            field_d = MC_RUN;
         end
      endcase
      if (init_req && (state_q != PS_RUN)) ign_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_RUN;
         field_q <= MC_RUN;
         ign_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         field_q <= field_d;
         ign_q   <= ign_d;
      end
   end

   assign state_o      = state_q;
   assign field_o      = field_q;
   assign ign_o        = ign_q;
   assign stop_entry_o = (state_d == PS_STOP) && (state_q != PS_STOP);

   // R3: stop is entered only from sleep
   a_r3_stop_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == PS_STOP) && ($past(state_q) != PS_STOP)) |-> ($past(state_q) == PS_SLEEP));

   // R4: stop is left only into sleep
   a_r4_stop_exit_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(state_q) == PS_STOP) && (state_q != PS_STOP)) |-> (state_q == PS_SLEEP));

   // R3: a refused request leaves the stored code unchanged
   a_r3_ignore_keeps_field: assert property (@(posedge clk) disable iff (!rst_n)
      ign_q |-> $stable(field_q));

   // R9: a pin change seen in sleep ends sleep
   a_r9_wake_exits_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == PS_SLEEP) && wake_i) |=> (state_q == PS_RUN));

endmodule

// File: rtl/canpwr_gate.sv
module canpwr_gate
   import canpwr_pkg::*;
#(
   parameter int AW      = 8,
   parameter int NUM_PTR = 4,
   parameter logic [NUM_PTR*AW-1:0] PTR_ADDRS = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pstate_e       state_i,
   input  logic          stop_entry_i,
   input  logic          reg_wr,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   input  logic          buf_req,
   input  logic          tx_req,
   input  logic          init_req,
   input  logic          bufon_set,
   output logic          clk_en,
   output logic          reg_wr_grant,
   output logic          rd_grant,
   output logic          buf_grant,
   output logic          tx_go,
   output logic          init_go,
   output logic          bufon
);

   generate
      if (NUM_PTR < 1) begin : g_bad_ptr
         $error("canpwr_gate: NUM_PTR must be at least 1");
      end
   endgenerate

   logic [NUM_PTR-1:0] ptr_hit;
   logic               stopped, running, bufon_q;

   generate
      for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
         assign ptr_hit[p] = (rd_addr == PTR_ADDRS[p*AW +: AW]);
      end
   endgenerate

   assign stopped      = (state_i == PS_STOP);
   assign running      = (state_i == PS_RUN);
   assign clk_en       = !stopped;
   assign reg_wr_grant = reg_wr && !stopped;
   assign buf_grant    = buf_req && !stopped;
   assign rd_grant     = rd_en && !(stopped && (|ptr_hit));
   assign tx_go        = tx_req && running;
   assign init_go      = init_req && running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     bufon_q <= 1'b0;
      else if (stop_entry_i)          bufon_q <= 1'b0;
      else if (bufon_set && !stopped) bufon_q <= 1'b1;
   end

   assign bufon = bufon_q;

   // R7: the buffer-access flag is low throughout stop
   a_r7_bufon_low_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |-> !bufon_q);

endmodule

// File: rtl/canpwr_ctrl.sv
module canpwr_ctrl
   import canpwr_pkg::*;
#(
   parameter int   AW            = 8,
   parameter int   NUM_PTR       = 4,
   parameter logic [NUM_PTR*AW-1:0] PTR_ADDRS = {8'h2A, 8'h28, 8'h26, 8'h24},
   parameter int   SYNC_STAGES   = 2,
   parameter bit   WAKE_ANY_EDGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rxd,
   input  logic          mode_wr,
   input  logic [1:0]    mode_wdata,
   input  logic          reg_wr,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   input  logic          buf_req,
   input  logic          tx_req,
   input  logic          init_req,
   input  logic          bufon_set,
   output logic          clk_en,
   output logic [1:0]    pstate,
   output logic [1:0]    mode_field,
   output logic          req_ign,
   output logic          reg_wr_grant,
   output logic          rd_grant,
   output logic          buf_grant,
   output logic          tx_go,
   output logic          init_go,
   output logic          bufon
);

   logic    wake;
   logic    stop_entry;
   pstate_e state;

   canpwr_rx_wake #(
      .SYNC_STAGES  (SYNC_STAGES),
      .WAKE_ANY_EDGE(WAKE_ANY_EDGE),
      .IDLE_LEVEL   (1'b1)
   ) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .rxd   (rxd),
      .edge_o(wake)
   );

   canpwr_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wake_i      (wake),
      .mode_wr     (mode_wr),
      .mode_wdata  (mode_wdata),
      .init_req    (init_req),
      .state_o     (state),
      .field_o     (mode_field),
      .ign_o       (req_ign),
      .stop_entry_o(stop_entry)
   );

   canpwr_gate #(
      .AW       (AW),
      .NUM_PTR  (NUM_PTR),
      .PTR_ADDRS(PTR_ADDRS)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (state),
      .stop_entry_i(stop_entry),
      .reg_wr      (reg_wr),
      .rd_en       (rd_en),
      .rd_addr     (rd_addr),
      .buf_req     (buf_req),
      .tx_req      (tx_req),
      .init_req    (init_req),
      .bufon_set   (bufon_set),
      .clk_en      (clk_en),
      .reg_wr_grant(reg_wr_grant),
      .rd_grant    (rd_grant),
      .buf_grant   (buf_grant),
      .tx_go       (tx_go),
      .init_go     (init_go),
      .bufon       (bufon)
   );

   assign pstate = state;

   // R5: stop silences clock, transmission, buffer and register writes
   a_r5_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == PS_STOP) |-> (!clk_en && !tx_go && !buf_grant && !reg_wr_grant));

   // R8: initialization is accepted only in operating state
   a_r8_init_only_run: assert property (@(posedge clk) disable iff (!rst_n)
      init_go |-> (pstate == PS_RUN));

endmodule

// File: tb/canpwr_ctrl_bench.sv
module canpwr_ctrl_bench;

   localparam int AW = 8;

   typedef enum int {
      S_PSTATE, S_FIELD, S_IGN, S_CLKEN, S_TXGO,
      S_BUFG, S_RWG, S_RDG, S_INITGO, S_BUFON
   } sig_e;

   typedef struct {
      sig_e       s;
      logic [1:0] exp;
      string      req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rxd = 1'b1;
   logic          mode_wr = 1'b0;
   logic [1:0]    mode_wdata = 2'b00;
   logic          reg_wr = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          buf_req = 1'b0;
   logic          tx_req = 1'b0;
   logic          init_req = 1'b0;
   logic          bufon_set = 1'b0;
   logic          clk_en, req_ign, reg_wr_grant, rd_grant, buf_grant;
   logic          tx_go, init_go, bufon;
   logic [1:0]    pstate, mode_field;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   item_t sb_q[$];

   always #5 clk = ~clk;

   canpwr_ctrl u_canpwr_ctrl (
      .clk(clk), .rst_n(rst_n), .rxd(rxd),
      .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .reg_wr(reg_wr), .rd_en(rd_en), .rd_addr(rd_addr),
      .buf_req(buf_req), .tx_req(tx_req), .init_req(init_req),
      .bufon_set(bufon_set), .clk_en(clk_en), .pstate(pstate),
      .mode_field(mode_field), .req_ign(req_ign),
      .reg_wr_grant(reg_wr_grant), .rd_grant(rd_grant),
      .buf_grant(buf_grant), .tx_go(tx_go), .init_go(init_go),
      .bufon(bufon)
   );

   function automatic logic [1:0] actual(sig_e s);
      case (s)
         S_PSTATE: return pstate;
         S_FIELD:  return mode_field;
         S_IGN:    return {1'b0, req_ign};
         S_CLKEN:  return {1'b0, clk_en};
         S_TXGO:   return {1'b0, tx_go};
         S_BUFG:   return {1'b0, buf_grant};
         S_RWG:    return {1'b0, reg_wr_grant};
         S_RDG:    return {1'b0, rd_grant};
         S_INITGO: return {1'b0, init_go};
         default:  return {1'b0, bufon};
      endcase
   endfunction

   // monitor: compares queued expectations just after each rising edge
   always @(posedge clk) begin
      #2;
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         total++;
         if (actual(it.s) !== it.exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b",
                     it.req, it.s.name(), actual(it.s), it.exp);
         end
      end
   end

   task automatic expect_v(sig_e s, logic [1:0] v, string req);
      item_t it;
      it.s = s; it.exp = v; it.req = req;
      sb_q.push_back(it);
   endtask

   task automatic nxt();
      @(negedge clk);
      mode_wr = 1'b0; reg_wr = 1'b0; rd_en = 1'b0; buf_req = 1'b0;
      tx_req = 1'b0; init_req = 1'b0; bufon_set = 1'b0;
   endtask

   task automatic wr_mode(logic [1:0] d);
      mode_wr = 1'b1; mode_wdata = d;
   endtask

   task automatic exp_state(logic [1:0] ps, logic [1:0] fld, logic ign, string req);
      expect_v(S_PSTATE, ps, req);
      expect_v(S_FIELD, fld, req);
      expect_v(S_IGN, {1'b0, ign}, req);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) nxt();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, R11 transmit allowed when operating
      tx_req = 1'b1;
      exp_state(2'b00, 2'b00, 1'b0, "R1");
      expect_v(S_CLKEN, 2'b01, "R1");
      expect_v(S_BUFON, 2'b00, "R1");
      expect_v(S_TXGO, 2'b01, "R11");
      nxt();
      // R10 code 10 refused in operating
      wr_mode(2'b10); exp_state(2'b00, 2'b00, 1'b1, "R10"); nxt();
      // R3 stop refused from operating
      wr_mode(2'b11); exp_state(2'b00, 2'b00, 1'b1, "R3"); nxt();
      // R8 init accepted when operating
      init_req = 1'b1;
      expect_v(S_INITGO, 2'b01, "R8"); expect_v(S_IGN, 2'b00, "R8"); nxt();
      // R7 flag set outside stop
      bufon_set = 1'b1; expect_v(S_BUFON, 2'b01, "R7"); nxt();
      // R2 enter sleep, R11 no transmit in sleep
      wr_mode(2'b01); tx_req = 1'b1;
      exp_state(2'b01, 2'b01, 1'b0, "R2"); expect_v(S_TXGO, 2'b00, "R11"); nxt();
      // R8 init refused in sleep
      init_req = 1'b1;
      expect_v(S_INITGO, 2'b00, "R8"); expect_v(S_IGN, 2'b01, "R8"); nxt();
      // R10 code 10 refused in sleep
      wr_mode(2'b10); exp_state(2'b01, 2'b01, 1'b1, "R10"); nxt();
      // R3 stop from sleep, R7 flag cleared on entry
      wr_mode(2'b11); exp_state(2'b11, 2'b11, 1'b0, "R3");
      expect_v(S_BUFON, 2'b00, "R7"); expect_v(S_CLKEN, 2'b00, "R5"); nxt();
      // R5 requests blocked in stop, R7 set ignored
      tx_req = 1'b1; buf_req = 1'b1; reg_wr = 1'b1; bufon_set = 1'b1;
      expect_v(S_TXGO, 2'b00, "R5"); expect_v(S_BUFG, 2'b00, "R5");
      expect_v(S_RWG, 2'b00, "R5"); expect_v(S_CLKEN, 2'b00, "R5");
      expect_v(S_BUFON, 2'b00, "R7"); nxt();
      // R6 pointer reads blocked in stop, others allowed
      rd_en = 1'b1; rd_addr = 8'h24; expect_v(S_RDG, 2'b00, "R6"); nxt();
      rd_en = 1'b1; rd_addr = 8'h2A; expect_v(S_RDG, 2'b00, "R6"); nxt();
      rd_en = 1'b1; rd_addr = 8'h25; expect_v(S_RDG, 2'b01, "R6"); nxt();
      // R4 other codes refused in stop
      wr_mode(2'b00); exp_state(2'b11, 2'b11, 1'b1, "R4"); nxt();
      wr_mode(2'b11); exp_state(2'b11, 2'b11, 1'b1, "R4"); nxt();
      wr_mode(2'b10); exp_state(2'b11, 2'b11, 1'b1, "R4"); nxt();
      // R8 init refused in stop
      init_req = 1'b1;
      expect_v(S_INITGO, 2'b00, "R8"); expect_v(S_IGN, 2'b01, "R8"); nxt();
      // R4 pin change in stop has no effect
      rxd = 1'b0; idle(4);
      exp_state(2'b11, 2'b11, 1'b0, "R4"); nxt();
      // R4 leave stop into sleep
      wr_mode(2'b01); exp_state(2'b01, 2'b01, 1'b0, "R4");
      expect_v(S_CLKEN, 2'b01, "R4"); nxt();
      idle(3);
      exp_state(2'b01, 2'b01, 1'b0, "R4"); nxt();
      // R6 pointer readable in sleep
      rd_en = 1'b1; rd_addr = 8'h24; expect_v(S_RDG, 2'b01, "R6"); nxt();
      // R2 sleep back to operating, then sleep again
      wr_mode(2'b00); exp_state(2'b00, 2'b00, 1'b0, "R2"); nxt();
      wr_mode(2'b01); exp_state(2'b01, 2'b01, 1'b0, "R2"); nxt();
      // R9 wake racing a stop request in the same cycle
      rxd = 1'b1; nxt(); nxt();
      wr_mode(2'b11); exp_state(2'b00, 2'b01, 1'b1, "R9"); nxt();
      wr_mode(2'b11); exp_state(2'b00, 2'b01, 1'b1, "R9"); nxt();
      wr_mode(2'b00); exp_state(2'b00, 2'b00, 1'b0, "R9"); nxt();
      // R9 plain wake from sleep
      wr_mode(2'b01); exp_state(2'b01, 2'b01, 1'b0, "R9"); nxt();
      rxd = 1'b0; idle(4);
      exp_state(2'b00, 2'b01, 1'b0, "R9"); nxt();
      wr_mode(2'b00); exp_state(2'b00, 2'b00, 1'b0, "R9"); nxt();
      idle(2);
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule